// File: doc/BRIEF.md
# Power-Mode and Clock-Gating Controller

This block tracks the operating mode of a chip and derives from it the clock enables of the core, the memories, the peripheral fabric, the watchdog and the CAN controller. It also derives a PWM output-disable, a stretched system reset and a retained boot-select bit. Software moves the chip between modes with debug, wait and stop strobes. Interrupt lines and a CAN wake-up line bring it back.

Reset sources are ranked. A cold source is the asynchronous power-on input or the synchronously sampled reset pin, and it clears the boot-select bit. A warm source is a watchdog timeout or a software request, and it leaves that bit alone. Software can therefore choose the boot source for the next warm restart. A separate PLL power-down bit is written by software. Entering stop never changes that bit.

The state machine has five states: `PM_RST`, `PM_RUN`, `PM_WAIT`, `PM_STOP` and `PM_DEBUG`. Its transitions are:
- RESET_HOLD: any state goes to `PM_RST` while the system reset is high.
- BOOT: `PM_RST` goes to `PM_RUN` once the reset is low.
- ENTER_DEBUG: `PM_RUN`, `PM_WAIT` or `PM_STOP` goes to `PM_DEBUG`.
- ENTER_STOP: `PM_RUN` goes to `PM_STOP`.
- ENTER_WAIT: `PM_RUN` goes to `PM_WAIT`.
- WAKE: `PM_WAIT` or `PM_STOP` goes to `PM_RUN`.
- LEAVE_DEBUG: `PM_DEBUG` goes to `PM_RUN`.

Top module: `pmcg_ctrl`

## Requirements
- R1: A low `por_n` (asynchronous) or a `pin_rst_n` sampled low at a clock edge asserts `sys_rst` and clears both `boot_mode` and `pll_pd` to 0.
- R2: A `wdog_to` or `sw_rst_req` sampled high asserts `sys_rst` after that edge and clears `pll_pd`, but `boot_mode` keeps its value.
- R3: When a cold source and a warm source are sampled in the same cycle, the cold source wins and `boot_mode` is cleared.
- R4: `sys_rst` stays high until 16 consecutive edges have passed with no source sampled, and then falls. One edge later the state is `PM_RUN`. In `PM_RST` every clock enable is 1 and `pwm_off` is 1.
- R5: In `PM_RUN` all five clock enables are 1 and `pwm_off` is 0.
- R6: In `PM_WAIT` the core and memory enables are 0 and the peripheral and CAN enables are 1. The watchdog enable equals `!cfg_wait_wdog_off`, and `pwm_off` equals `cfg_wait_pwm_off`.
- R7: In `PM_STOP` the core, memory and peripheral enables are 0. The watchdog enable equals `!cfg_stop_wdog_off`, the CAN enable equals `!cfg_stop_can_off`, and `pwm_off` is 1.
- R8: In `PM_DEBUG` the core, memory, peripheral and CAN enables are 1 and the watchdog enable is 0. `pwm_off` equals `cfg_dbg_pwm_off`.
- R9: In `PM_RUN` the request strobes are ranked `dbg_enter` above `stop_req` above `wait_req`. The winner takes effect at the next edge.
- R10: A wake event is registered at one edge, and the state returns to `PM_RUN` (clock enables back on) at the following edge. In `PM_WAIT` a wake event is any bit of `irq`. In `PM_STOP` it is any bit of `irq` or `can_wake`. `irq` has no effect in `PM_RUN`.
- R11: In `PM_STOP` with `cfg_stop_can_off`=1, `can_wake` is ignored and the chip stays stopped.
- R12: `dbg_enter` in `PM_WAIT` or `PM_STOP` wins over a wake event in the same cycle. `dbg_exit` returns `PM_DEBUG` to `PM_RUN` and has no effect in other states.
- R13: `boot_wr` and `pll_wr` load `boot_val` and `pll_val` only in `PM_RUN` with no reset pending; in any other state they are ignored. Entering `PM_STOP` leaves `pll_pd` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_rst_n | input | 1 | External reset pin, active low, sampled on clk |
| wdog_to | input | 1 | Watchdog timeout, warm reset source |
| sw_rst_req | input | 1 | Software reset request, warm reset source |
| dbg_enter | input | 1 | Debug entry request |
| dbg_exit | input | 1 | Debug exit request |
| wait_req | input | 1 | Wait instruction strobe |
| stop_req | input | 1 | Stop instruction strobe |
| can_wake | input | 1 | Wake-up indication from the CAN domain |
| irq | input | NIRQ | Ungated interrupt lines |
| cfg_wait_wdog_off | input | 1 | Stop watchdog clock in wait |
| cfg_wait_pwm_off | input | 1 | Force PWM outputs off in wait |
| cfg_stop_wdog_off | input | 1 | Stop watchdog clock in stop |
| cfg_stop_can_off | input | 1 | Stop CAN clock in stop |
| cfg_dbg_pwm_off | input | 1 | Force PWM outputs off in debug |
| boot_wr | input | 1 | Write strobe for the boot-select bit |
| boot_val | input | 1 | Value written to the boot-select bit |
| pll_wr | input | 1 | Write strobe for the PLL power-down bit |
| pll_val | input | 1 | Value written to the PLL power-down bit |
| core_ce | output | 1 | Core clock enable |
| mem_ce | output | 1 | Memory clock enable |
| periph_ce | output | 1 | Peripheral clock enable |
| wdog_ce | output | 1 | Watchdog clock enable |
| can_ce | output | 1 | CAN clock enable |
| pwm_off | output | 1 | Force PWM outputs to their safe state |
| sys_rst | output | 1 | Stretched system reset |
| boot_mode | output | 1 | Retained boot-select bit |
| pll_pd | output | 1 | PLL power-down control |

## Verification
A wake event and a debug entry can arrive in the same cycle while the chip is in wait or stop. Both are legal exits, so the rank between them is the point under test. For every setting of the five gating bits, the bench raises an interrupt together with `dbg_enter` in wait. It then judges the state that follows by its output signature: the watchdog enable must be 0 while core and memory run, which is the debug signature and not the run signature. It also holds a CAN wake in stop under both CAN gating settings and checks that only the clocked setting leaves stop.

// File: rtl/pmcg_pkg.sv
package pmcg_pkg;

    typedef enum logic [2:0] {
        PM_RST   = 3'd0,
        PM_RUN   = 3'd1,
        PM_WAIT  = 3'd2,
        PM_STOP  = 3'd3,
        PM_DEBUG = 3'd4
    } pm_state_e;

    typedef struct packed {
        logic core;
        logic mem;
        logic periph;
        logic wdog;
        logic can;
        logic pwm_off;
    } gate_t;

endpackage

// File: rtl/pmcg_rst_seq.sv
module pmcg_rst_seq #(
    parameter int STRETCH = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_rst_n,
    input  logic wdog_to,
    input  logic sw_rst_req,
    output logic src_hit,
    output logic cold_hit,
    output logic sys_rst
);
    localparam int CW = $clog2(STRETCH + 1);

    logic [CW-1:0] cnt;

    // ranked sources: pin (cold) outranks watchdog, watchdog outranks software
    always_comb begin
        cold_hit = 1'b0;
        src_hit  = 1'b1;
        if (!pin_rst_n)      cold_hit = 1'b1;
        else if (wdog_to)    cold_hit = 1'b0;
        else if (sw_rst_req) cold_hit = 1'b0;
        else                 src_hit  = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          cnt <= CW'(STRETCH);
        else if (src_hit)    cnt <= CW'(STRETCH);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign sys_rst = (cnt != '0);

    AST_RST_ON_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
        src_hit |=> sys_rst);  // R1
    AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (!por_n)
        cnt <= CW'(STRETCH));  // R4
endmodule

// File: rtl/pmcg_mode_fsm.sv
module pmcg_mode_fsm
    import pmcg_pkg::*;
#(
    parameter int NIRQ = 4
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            sys_rst,
    input  logic            dbg_enter,
    input  logic            dbg_exit,
    input  logic            wait_req,
    input  logic            stop_req,
    input  logic [NIRQ-1:0] irq,
    input  logic            can_wake,
    input  logic            cfg_stop_can_off,
    output pm_state_e       state
);
    pm_state_e nxt;
    logic      wake_q;
    logic      low_pwr;
    logic      wake_cond;

    assign low_pwr   = (state == PM_WAIT) || (state == PM_STOP);
    assign wake_cond = ((state == PM_WAIT) && (|irq)) ||
                       ((state == PM_STOP) && ((|irq) || (can_wake && !cfg_stop_can_off)));

    always_comb begin
        nxt = state;
        unique case (state)
            PM_RST:   if (!sys_rst) nxt = PM_RUN;
            PM_RUN: begin
                if (dbg_enter)     nxt = PM_DEBUG;
                else if (stop_req) nxt = PM_STOP;
                else if (wait_req) nxt = PM_WAIT;
            end
            PM_WAIT, PM_STOP: begin
                if (dbg_enter)     nxt = PM_DEBUG;
                else if (wake_q)   nxt = PM_RUN;
            end
            PM_DEBUG: if (dbg_exit) nxt = PM_RUN;
            default:  nxt = PM_RST;
        endcase
        if (sys_rst) nxt = PM_RST;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state  <= PM_RST;
            wake_q <= 1'b0;
        end else begin
            state  <= nxt;
            wake_q <= wake_cond && !wake_q && !sys_rst;
        end
    end

    AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!por_n)
        (low_pwr && wake_q && !dbg_enter && !sys_rst) |=> (state == PM_RUN));  // R10
    AST_DEBUG_WINS: assert property (@(posedge clk) disable iff (!por_n)
        (low_pwr && dbg_enter && !sys_rst) |=> (state == PM_DEBUG));  // R12
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (state == PM_RST));  // R4
endmodule

// File: rtl/pmcg_gate_dec.sv
module pmcg_gate_dec
    import pmcg_pkg::*;
(
    input  pm_state_e state,
    input  logic      cfg_wait_wdog_off,
    input  logic      cfg_wait_pwm_off,
    input  logic      cfg_stop_wdog_off,
    input  logic      cfg_stop_can_off,
    input  logic      cfg_dbg_pwm_off,
    output gate_t     gate
);
    always_comb begin
        gate = '{core: 1'b1, mem: 1'b1, periph: 1'b1, wdog: 1'b1, can: 1'b1, pwm_off: 1'b0};
        unique case (state)
            PM_RST:   gate.pwm_off = 1'b1;
            PM_RUN:   ;
            PM_WAIT: begin
                gate.core    = 1'b0;
                gate.mem     = 1'b0;
                gate.wdog    = !cfg_wait_wdog_off;
                gate.pwm_off = cfg_wait_pwm_off;
            end
            PM_STOP: begin
                gate.core    = 1'b0;
                gate.mem     = 1'b0;
                gate.periph  = 1'b0;
                gate.wdog    = !cfg_stop_wdog_off;
                gate.can     = !cfg_stop_can_off;
                gate.pwm_off = 1'b1;
            end
            PM_DEBUG: begin
                gate.wdog    = 1'b0;
                gate.pwm_off = cfg_dbg_pwm_off;
            end
            default:  gate.pwm_off = 1'b1;
        endcase
    end
endmodule

// File: rtl/pmcg_sw_regs.sv
module pmcg_sw_regs
    import pmcg_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  pm_state_e state,
    input  logic      src_hit,
    input  logic      cold_hit,
    input  logic      sys_rst,
    input  logic      boot_wr,
    input  logic      boot_val,
    input  logic      pll_wr,
    input  logic      pll_val,
    output logic      boot_mode,
    output logic      pll_pd
);
    logic wr_ok;

    assign wr_ok = (state == PM_RUN) && !src_hit && !sys_rst;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                boot_mode <= 1'b0;
        else if (cold_hit)         boot_mode <= 1'b0;
        else if (wr_ok && boot_wr) boot_mode <= boot_val;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                pll_pd <= 1'b0;
        else if (src_hit || sys_rst) pll_pd <= 1'b0;
        else if (wr_ok && pll_wr)  pll_pd <= pll_val;
    end

    AST_BOOT_RETAINED: assert property (@(posedge clk) disable iff (!por_n)
        (!cold_hit && (state != PM_RUN)) |=> $stable(boot_mode));  // R2
    AST_COLD_CLEARS_BOOT: assert property (@(posedge clk) disable iff (!por_n)
        cold_hit |=> !boot_mode);  // R3
endmodule

// File: rtl/pmcg_ctrl.sv
module pmcg_ctrl
    import pmcg_pkg::*;
#(
    parameter int NIRQ    = 4,
    parameter int STRETCH = 16
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            pin_rst_n,
    input  logic            wdog_to,
    input  logic            sw_rst_req,
    input  logic            dbg_enter,
    input  logic            dbg_exit,
    input  logic            wait_req,
    input  logic            stop_req,
    input  logic            can_wake,
    input  logic [NIRQ-1:0] irq,
    input  logic            cfg_wait_wdog_off,
    input  logic            cfg_wait_pwm_off,
    input  logic            cfg_stop_wdog_off,
    input  logic            cfg_stop_can_off,
    input  logic            cfg_dbg_pwm_off,
    input  logic            boot_wr,
    input  logic            boot_val,
    input  logic            pll_wr,
    input  logic            pll_val,
    output logic            core_ce,
    output logic            mem_ce,
    output logic            periph_ce,
    output logic            wdog_ce,
    output logic            can_ce,
    output logic            pwm_off,
    output logic            sys_rst,
    output logic            boot_mode,
    output logic            pll_pd
);
    logic      src_hit;
    logic      cold_hit;
    pm_state_e state;
    gate_t     gate;

    pmcg_rst_seq #(.STRETCH(STRETCH)) u_rst (
        .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .wdog_to(wdog_to),
        .sw_rst_req(sw_rst_req), .src_hit(src_hit), .cold_hit(cold_hit),
        .sys_rst(sys_rst)
    );

    pmcg_mode_fsm #(.NIRQ(NIRQ)) u_fsm (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .dbg_enter(dbg_enter),
        .dbg_exit(dbg_exit), .wait_req(wait_req), .stop_req(stop_req),
        .irq(irq), .can_wake(can_wake), .cfg_stop_can_off(cfg_stop_can_off),
        .state(state)
    );

    pmcg_gate_dec u_dec (
        .state(state), .cfg_wait_wdog_off(cfg_wait_wdog_off),
        .cfg_wait_pwm_off(cfg_wait_pwm_off), .cfg_stop_wdog_off(cfg_stop_wdog_off),
        .cfg_stop_can_off(cfg_stop_can_off), .cfg_dbg_pwm_off(cfg_dbg_pwm_off),
        .gate(gate)
    );

    pmcg_sw_regs u_regs (
        .clk(clk), .por_n(por_n), .state(state), .src_hit(src_hit),
        .cold_hit(cold_hit), .sys_rst(sys_rst), .boot_wr(boot_wr),
        .boot_val(boot_val), .pll_wr(pll_wr), .pll_val(pll_val),
        .boot_mode(boot_mode), .pll_pd(pll_pd)
    );

    assign core_ce   = gate.core;
    assign mem_ce    = gate.mem;
    assign periph_ce = gate.periph;
    assign wdog_ce   = gate.wdog;
    assign can_ce    = gate.can;
    assign pwm_off   = gate.pwm_off;

    AST_DEBUG_WDOG_OFF: assert property (@(posedge clk) disable iff (!por_n)
        (state == PM_DEBUG) |-> (!wdog_ce && core_ce));  // R8
    AST_LOWPWR_CORE_OFF: assert property (@(posedge clk) disable iff (!por_n)
        ((state == PM_WAIT) || (state == PM_STOP)) |-> (!core_ce && !mem_ce));  // R6
    AST_STOP_KEEPS_PLL: assert property (@(posedge clk) disable iff (!por_n)
        ((state == PM_STOP) && ($past(state) == PM_RUN)) |-> (pll_pd == $past(pll_pd)));  // R13
endmodule

// File: tb/test_pmcg_ctrl.sv
module test_pmcg_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 4;
    localparam int STRETCH    = 16;

    logic clk = 1'b0;
    logic por_n = 1'b0, pin_rst_n = 1'b1, wdog_to = 1'b0, sw_rst_req = 1'b0;
    logic dbg_enter = 1'b0, dbg_exit = 1'b0, wait_req = 1'b0, stop_req = 1'b0;
    logic can_wake = 1'b0;
    logic [NIRQ-1:0] irq = '0;
    logic cfg_wait_wdog_off = 1'b0, cfg_wait_pwm_off = 1'b0, cfg_stop_wdog_off = 1'b0;
    logic cfg_stop_can_off = 1'b0, cfg_dbg_pwm_off = 1'b0;
    logic boot_wr = 1'b0, boot_val = 1'b0, pll_wr = 1'b0, pll_val = 1'b0;
    logic core_ce, mem_ce, periph_ce, wdog_ce, can_ce, pwm_off, sys_rst, boot_mode, pll_pd;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmcg_ctrl #(.NIRQ(NIRQ), .STRETCH(STRETCH)) i_pmcg_ctrl (
        .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .wdog_to(wdog_to),
        .sw_rst_req(sw_rst_req), .dbg_enter(dbg_enter), .dbg_exit(dbg_exit),
        .wait_req(wait_req), .stop_req(stop_req), .can_wake(can_wake), .irq(irq),
        .cfg_wait_wdog_off(cfg_wait_wdog_off), .cfg_wait_pwm_off(cfg_wait_pwm_off),
        .cfg_stop_wdog_off(cfg_stop_wdog_off), .cfg_stop_can_off(cfg_stop_can_off),
        .cfg_dbg_pwm_off(cfg_dbg_pwm_off), .boot_wr(boot_wr), .boot_val(boot_val),
        .pll_wr(pll_wr), .pll_val(pll_val), .core_ce(core_ce), .mem_ce(mem_ce),
        .periph_ce(periph_ce), .wdog_ce(wdog_ce), .can_ce(can_ce), .pwm_off(pwm_off),
        .sys_rst(sys_rst), .boot_mode(boot_mode), .pll_pd(pll_pd)
    );

    // mode codes for the expected-value model: 0 rst, 1 run, 2 wait, 3 stop, 4 debug
    function automatic logic [5:0] exp_gate(int mode, logic [4:0] c);
        logic [5:0] g;
        case (mode)
            0: g = 6'b111111;
            1: g = 6'b111110;
            2: g = {1'b0, 1'b0, 1'b1, !c[0], 1'b1, c[1]};
            3: g = {1'b0, 1'b0, 1'b0, !c[2], !c[3], 1'b1};
            default: g = {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, c[4]};
        endcase
        return g;
    endfunction

    function automatic logic [5:0] act_gate();
        return {core_ce, mem_ce, periph_ce, wdog_ce, can_ce, pwm_off};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reset_tail(string req);
        repeat (STRETCH - 1) step();
        chk(req, {7'd0, sys_rst}, 8'd1);
        step();
        chk(req, {7'd0, sys_rst}, 8'd0);
        step();
        chk("R4 run after release", {2'b0, act_gate()}, {2'b0, exp_gate(1, 5'd0)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [4:0] c;
        repeat (3) @(negedge clk);
        // R1 power-on
        chk("R1 por sys_rst", {7'd0, sys_rst}, 8'd1);
        chk("R1 por boot", {6'd0, boot_mode, pll_pd}, 8'd0);
        chk("R4 reset gating", {2'b0, act_gate()}, {2'b0, exp_gate(0, 5'd0)});
        por_n = 1'b1;
        reset_tail("R4 stretch after por");

        // R13 writes in run
        boot_wr = 1'b1; boot_val = 1'b1; pll_wr = 1'b1; pll_val = 1'b1;
        step();
        boot_wr = 1'b0; pll_wr = 1'b0;
        chk("R13 write in run", {6'd0, boot_mode, pll_pd}, 8'b11);

        // R2 warm reset via watchdog
        wdog_to = 1'b1; step(); wdog_to = 1'b0;
        chk("R2 wdog sys_rst", {7'd0, sys_rst}, 8'd1);
        chk("R2 wdog keeps boot", {6'd0, boot_mode, pll_pd}, 8'b10);
        reset_tail("R2 wdog stretch");
        sw_rst_req = 1'b1; step(); sw_rst_req = 1'b0;
        chk("R2 sw keeps boot", {6'd0, boot_mode, sys_rst}, 8'b11);
        reset_tail("R2 sw stretch");

        // R3 cold and warm together
        pin_rst_n = 1'b0; wdog_to = 1'b1; step(); pin_rst_n = 1'b1; wdog_to = 1'b0;
        chk("R3 cold wins", {6'd0, boot_mode, sys_rst}, 8'b01);
        reset_tail("R1 pin stretch");

        // R10 irq ignored in run
        irq = 4'b0100; step(); step(); irq = '0;
        chk("R10 irq in run", {2'b0, act_gate()}, {2'b0, exp_gate(1, 5'd0)});
        // R12 dbg_exit ignored in run
        dbg_exit = 1'b1; step(); dbg_exit = 1'b0;
        chk("R12 exit in run", {2'b0, act_gate()}, {2'b0, exp_gate(1, 5'd0)});

        // R9 ranking
        wait_req = 1'b1; stop_req = 1'b1; step(); wait_req = 1'b0; stop_req = 1'b0;
        chk("R9 stop over wait", {2'b0, act_gate()}, {2'b0, exp_gate(3, 5'd0)});
        irq = 4'b0001; step(); irq = '0; step();
        dbg_enter = 1'b1; stop_req = 1'b1; step(); dbg_enter = 1'b0; stop_req = 1'b0;
        chk("R9 debug over stop", {2'b0, act_gate()}, {2'b0, exp_gate(4, 5'd0)});
        dbg_exit = 1'b1; step(); dbg_exit = 1'b0;

        // R13 writes ignored outside run, stop keeps pll
        pll_wr = 1'b1; pll_val = 1'b1; step(); pll_wr = 1'b0;
        stop_req = 1'b1; step(); stop_req = 1'b0;
        chk("R13 stop keeps pll", {7'd0, pll_pd}, 8'd1);
        boot_wr = 1'b1; boot_val = 1'b1; pll_wr = 1'b1; pll_val = 1'b0; step();
        boot_wr = 1'b0; pll_wr = 1'b0;
        chk("R13 write ignored in stop", {6'd0, boot_mode, pll_pd}, 8'b01);
        irq = 4'b1000; step(); irq = '0; step();

        // sweep over all gating settings
        for (int k = 0; k < 32; k++) begin
            c = 5'(k);
            {cfg_dbg_pwm_off, cfg_stop_can_off, cfg_stop_wdog_off, cfg_wait_pwm_off, cfg_wait_wdog_off} = c;
            // wait entry and wake timing
            wait_req = 1'b1; step(); wait_req = 1'b0;
            chk("R6 wait gating", {2'b0, act_gate()}, {2'b0, exp_gate(2, c)});
            irq = 4'(1 << (k % NIRQ)); step(); irq = '0;
            chk("R10 wait wake registered", {2'b0, act_gate()}, {2'b0, exp_gate(2, c)});
            step();
            chk("R10 wait wake done", {2'b0, act_gate()}, {2'b0, exp_gate(1, c)});
            // stop entry and CAN wake
            stop_req = 1'b1; step(); stop_req = 1'b0;
            chk("R7 stop gating", {2'b0, act_gate()}, {2'b0, exp_gate(3, c)});
            can_wake = 1'b1; step(); can_wake = 1'b0; step();
            if (c[3]) begin
                chk("R11 can wake ignored", {2'b0, act_gate()}, {2'b0, exp_gate(3, c)});
                irq = 4'b0010; step(); irq = '0; step();
            end
            chk("R10 stop wake", {2'b0, act_gate()}, {2'b0, exp_gate(1, c)});
            // collision of wake and debug entry in wait
            wait_req = 1'b1; step(); wait_req = 1'b0;
            irq = 4'b0001; dbg_enter = 1'b1; step(); irq = '0; dbg_enter = 1'b0;
            chk("R12 debug beats wake", {2'b0, act_gate()}, {2'b0, exp_gate(4, c)});
            step();
            chk("R8 debug gating", {2'b0, act_gate()}, {2'b0, exp_gate(4, c)});
            dbg_exit = 1'b1; step(); dbg_exit = 1'b0;
            chk("R12 debug exit", {2'b0, act_gate()}, {2'b0, exp_gate(1, c)});
            chk("R5 run sys_rst low", {7'd0, sys_rst}, 8'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule